// File: doc/BRIEF.md
# First-Come Shared Bus Arbiter

This block models a wide internal shared bus that many logic sources can drive, without tristate drivers. The bus is a set of 9-bit groups. Each group carries a data byte with an odd-parity bit. A static partition setting joins these groups into lanes of 9, 18 or 36 bits. Every source has its own data word across the whole bus and one enable bit per group. A source asks for a lane by raising any of its enables on that lane's groups.

A lane belongs to the source that asked for it first. The lane stays with that source for as long as the source keeps asking, and every later requester is shut out, so two sources never drive the same lane. When nobody drives a lane, the lane shows the last value that was driven on it. Each group has a two-state machine. GRP_IDLE moves to GRP_OWNED on a grant, which goes to the lowest-indexed source that is asking. GRP_OWNED moves back to GRP_IDLE on a release, which happens when the owner stops asking. All the groups of one lane take the same decisions in step.

The outputs are the bus value, a busy flag and an owner index for every group, a parity-error flag for every group, and the partition that is in force. The partition can only change when the whole bus is quiet.

Top module: `fcfs_shared_bus`

## Requirements
- R1: `mode_sel` codes are 0 for twelve 9-bit lanes, 1 for six 18-bit lanes and 2 for three 36-bit lanes. Lane n covers groups n*S to n*S+S-1, where S is 1, 2 or 4. A source requests a lane if any of its enable bits on that lane's groups is set. All groups of a lane show the same busy flag and the same owner.
- R2: A lane in GRP_IDLE with one or more requesters is granted at the next clock edge to the lowest-indexed requester. After that edge its busy flag is high and its owner output gives that source index.
- R3: While the owner keeps requesting, the owner does not change and the data of other sources never appears on the lane.
- R4: In the cycle the owner drops its request, the lane is not driven. At the next edge the lane returns to GRP_IDLE with busy low. A source that is still requesting is granted one edge after that, with no need to re-request.
- R5: While the owner requests, each group of the lane shows that owner's data for the group in the same cycle.
- R6: A group that is not driven shows the last value driven on it. That value is zero after reset.
- R7: `parity_err` for a group is high only when the group is driven and its 9 bits hold an even number of ones. Otherwise it is low.
- R8: `mode_sel` takes effect at a clock edge only if every group is idle, no enable bit is set and the code is not 3. At any other time the setting is ignored and `mode_now` keeps its value.
- R9: Reset leaves all groups idle with owner 0, the bus at zero and `mode_now` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Requested lane partition |
| src_en | input | NSRC*NGRP | Enables; bit s*NGRP+g is source s on group g |
| src_data | input | NSRC*BUS_W | Data; source s occupies bits s*BUS_W upward |
| bus_data | output | BUS_W | Resolved bus value |
| grp_busy | output | NGRP | Group is owned |
| grp_owner | output | NGRP*IDXW | Owner index of group g at bits g*IDXW upward, 0 when idle |
| parity_err | output | NGRP | Driven group has even parity |
| mode_now | output | 2 | Partition in force |

## Verification
Bus data and parity respond to enables and data in the same cycle. The bench therefore drives inputs just after a falling edge and compares these outputs one time unit later. Busy and owner change one edge after a request or a release, so a handover shows up two edges after the owner lets go. The partition changes one edge after a quiet cycle. The bench model advances its own state at each rising edge from the inputs it drove, and the next comparison uses that updated state.

// File: rtl/shbus_pkg.sv
package shbus_pkg;
    typedef enum logic [1:0] {
        LANES_9   = 2'd0,
        LANES_18  = 2'd1,
        LANES_36  = 2'd2,
        LANES_BAD = 2'd3
    } lane_mode_e;

    typedef enum logic {
        GRP_IDLE  = 1'b0,
        GRP_OWNED = 1'b1
    } grp_state_e;

    function automatic int unsigned span_of(input lane_mode_e m);
        unique case (m)
            LANES_18: return 2;
            LANES_36: return 4;
            default:  return 1;
        endcase
    endfunction
endpackage

// File: rtl/shbus_lane_req.sv
module shbus_lane_req
    import shbus_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int NGRP = 12
) (
    input  lane_mode_e               mode,
    input  logic [NSRC*NGRP-1:0]     src_en,
    output logic [NGRP*NSRC-1:0]     lane_req
);
    always_comb begin
        int unsigned span;
        span = span_of(mode);
        lane_req = '0;
        for (int g = 0; g < NGRP; g++) begin
            for (int s = 0; s < NSRC; s++) begin
                for (int k = 0; k < NGRP; k++) begin
                    if ((k / span) == (g / span)) begin
                        lane_req[g*NSRC+s] = lane_req[g*NSRC+s] | src_en[s*NGRP+k];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/shbus_grp_arb.sv
module shbus_grp_arb
    import shbus_pkg::*;
#(
    parameter int NSRC  = 4,
    parameter int GRP_W = 9,
    parameter int IDXW  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSRC-1:0]         req,
    input  logic [NSRC*GRP_W-1:0]   grp_in,
    output logic                    busy,
    output logic [IDXW-1:0]         owner,
    output logic [GRP_W-1:0]        grp_out,
    output logic                    par_err
);
    grp_state_e          state_q, state_d;
    logic [IDXW-1:0]     owner_q, owner_d, first_req;
    logic [GRP_W-1:0]    hold_q;
    logic                drive;

    always_comb begin
        first_req = '0;
        for (int s = NSRC - 1; s >= 0; s--) begin
            if (req[s]) first_req = IDXW'(s);
        end
    end

    // next-state: grant from idle, release from owned
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            GRP_IDLE: begin
                if (|req) begin
                    state_d = GRP_OWNED;
                    owner_d = first_req;
                end
            end
            GRP_OWNED: begin
                if (!req[owner_q]) begin
                    state_d = GRP_IDLE;
                    owner_d = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GRP_IDLE;
            owner_q <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            hold_q  <= grp_out;
        end
    end

    // outputs
    always_comb begin
        drive   = (state_q == GRP_OWNED) && req[owner_q];
        grp_out = drive ? grp_in[int'(owner_q)*GRP_W +: GRP_W] : hold_q;
        par_err = drive && !(^grp_out);
        busy    = (state_q == GRP_OWNED);
        owner   = owner_q;
    end

    assert_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GRP_IDLE && |req) |=> (state_q == GRP_OWNED));

    assert_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GRP_OWNED && req[owner_q]) |=>
            (state_q == GRP_OWNED && owner_q == $past(owner_q)));

    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GRP_OWNED && !req[owner_q]) |=> (state_q == GRP_IDLE));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GRP_IDLE) |-> (grp_out == $past(grp_out)));

    assert_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> (state_q == GRP_OWNED));
endmodule

// File: rtl/shbus_mode_ctl.sv
module shbus_mode_ctl
    import shbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  lane_mode_e  mode_sel,
    input  logic        any_busy,
    input  logic        any_en,
    output lane_mode_e  mode_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= LANES_9;
        end else if (!any_busy && !any_en && mode_sel != LANES_BAD) begin
            mode_q <= mode_sel;
        end
    end

    assert_mode_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |-> (!$past(any_busy) && !$past(any_en)));
endmodule

// File: rtl/fcfs_shared_bus.sv
module fcfs_shared_bus
    import shbus_pkg::*;
#(
    parameter int NSRC  = 4,
    parameter int GRP_W = 9,
    parameter int NGRP  = 12,
    localparam int BUS_W = GRP_W * NGRP,
    localparam int IDXW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              mode_sel,
    input  logic [NSRC*NGRP-1:0]    src_en,
    input  logic [NSRC*BUS_W-1:0]   src_data,
    output logic [BUS_W-1:0]        bus_data,
    output logic [NGRP-1:0]         grp_busy,
    output logic [NGRP*IDXW-1:0]    grp_owner,
    output logic [NGRP-1:0]         parity_err,
    output logic [1:0]              mode_now
);
    lane_mode_e              mode_q;
    logic [NGRP*NSRC-1:0]    lane_req;

    shbus_mode_ctl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (lane_mode_e'(mode_sel)),
        .any_busy (|grp_busy),
        .any_en   (|src_en),
        .mode_q   (mode_q)
    );

    assign mode_now = mode_q;

    shbus_lane_req #(.NSRC(NSRC), .NGRP(NGRP)) u_req (
        .mode     (mode_q),
        .src_en   (src_en),
        .lane_req (lane_req)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [NSRC*GRP_W-1:0] grp_in;
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            assign grp_in[s*GRP_W +: GRP_W] = src_data[s*BUS_W + g*GRP_W +: GRP_W];
        end

        shbus_grp_arb #(.NSRC(NSRC), .GRP_W(GRP_W), .IDXW(IDXW)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (lane_req[g*NSRC +: NSRC]),
            .grp_in  (grp_in),
            .busy    (grp_busy[g]),
            .owner   (grp_owner[g*IDXW +: IDXW]),
            .grp_out (bus_data[g*GRP_W +: GRP_W]),
            .par_err (parity_err[g])
        );

        if (g % 2 != 0) begin : g_pair
            assert_lane18_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_q == LANES_18) |->
                    (grp_busy[g] == grp_busy[g-1] &&
                     grp_owner[g*IDXW +: IDXW] == grp_owner[(g-1)*IDXW +: IDXW]));
        end
        if (g % 4 != 0) begin : g_quad
            assert_lane36_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_q == LANES_36) |->
                    (grp_busy[g] == grp_busy[g-1] &&
                     grp_owner[g*IDXW +: IDXW] == grp_owner[(g-1)*IDXW +: IDXW]));
        end
    end
endmodule

// File: tb/fcfs_shared_bus_tb.sv
module fcfs_shared_bus_tb;
    localparam int NSRC  = 4;
    localparam int GRP_W = 9;
    localparam int NGRP  = 12;
    localparam int BUS_W = GRP_W * NGRP;
    localparam int IDXW  = 2;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [1:0]              mode_sel = 2'd0;
    logic [NSRC*NGRP-1:0]    src_en = '0;
    logic [NSRC*BUS_W-1:0]   src_data = '0;
    logic [BUS_W-1:0]        bus_data;
    logic [NGRP-1:0]         grp_busy;
    logic [NGRP*IDXW-1:0]    grp_owner;
    logic [NGRP-1:0]         parity_err;
    logic [1:0]              mode_now;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    bit              m_busy [NGRP];
    int              m_owner [NGRP];
    logic [BUS_W-1:0] m_hold;
    int              m_mode;

    always #5 clk = ~clk;

    fcfs_shared_bus #(.NSRC(NSRC), .GRP_W(GRP_W), .NGRP(NGRP)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .src_en(src_en),
        .src_data(src_data), .bus_data(bus_data), .grp_busy(grp_busy),
        .grp_owner(grp_owner), .parity_err(parity_err), .mode_now(mode_now)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit lreq(input int s, input int g);
        int span;
        bit r;
        span = 1 << m_mode;
        r = 1'b0;
        for (int k = 0; k < NGRP; k++)
            if ((k / span) == (g / span)) r = r | src_en[s*NGRP+k];
        return r;
    endfunction

    function automatic logic [BUS_W-1:0] exp_bus();
        logic [BUS_W-1:0] v;
        v = m_hold;
        for (int g = 0; g < NGRP; g++)
            if (m_busy[g] && lreq(m_owner[g], g))
                v[g*GRP_W +: GRP_W] = src_data[m_owner[g]*BUS_W + g*GRP_W +: GRP_W];
        return v;
    endfunction

    function automatic logic [NGRP-1:0] exp_par();
        logic [NGRP-1:0] p;
        logic [BUS_W-1:0] v;
        v = exp_bus();
        for (int g = 0; g < NGRP; g++)
            p[g] = m_busy[g] && lreq(m_owner[g], g) && !(^v[g*GRP_W +: GRP_W]);
        return p;
    endfunction

    function automatic logic [NGRP-1:0] exp_busy();
        logic [NGRP-1:0] b;
        for (int g = 0; g < NGRP; g++) b[g] = m_busy[g];
        return b;
    endfunction

    function automatic logic [NGRP*IDXW-1:0] exp_owner();
        logic [NGRP*IDXW-1:0] o;
        for (int g = 0; g < NGRP; g++) o[g*IDXW +: IDXW] = IDXW'(m_owner[g]);
        return o;
    endfunction

    task automatic model_reset();
        for (int g = 0; g < NGRP; g++) begin
            m_busy[g] = 1'b0;
            m_owner[g] = 0;
        end
        m_hold = '0;
        m_mode = 0;
    endtask

    task automatic model_clock();
        bit nb [NGRP];
        int no [NGRP];
        bit quiet;
        quiet = (src_en == '0);
        for (int g = 0; g < NGRP; g++) begin
            nb[g] = m_busy[g];
            no[g] = m_owner[g];
            if (m_busy[g]) quiet = 1'b0;
            if (m_busy[g]) begin
                if (!lreq(m_owner[g], g)) begin
                    nb[g] = 1'b0;
                    no[g] = 0;
                end
            end else begin
                for (int s = NSRC - 1; s >= 0; s--)
                    if (lreq(s, g)) begin
                        nb[g] = 1'b1;
                        no[g] = s;
                    end
            end
        end
        m_hold = exp_bus();
        for (int g = 0; g < NGRP; g++) begin
            m_busy[g] = nb[g];
            m_owner[g] = no[g];
        end
        if (quiet && mode_sel != 2'd3) m_mode = int'(mode_sel);
    endtask

    // inputs are set just after a falling edge; compare, clock, return at next falling edge
    task automatic step();
        #1;
        chk(bus_data == exp_bus(), "R5/R6 bus", 128'(bus_data), 128'(exp_bus()));
        chk(parity_err == exp_par(), "R7 parity", 128'(parity_err), 128'(exp_par()));
        chk(grp_busy == exp_busy(), "R2/R4 busy", 128'(grp_busy), 128'(exp_busy()));
        chk(grp_owner == exp_owner(), "R3 owner", 128'(grp_owner), 128'(exp_owner()));
        chk(int'(mode_now) == m_mode, "R8 mode", 128'(mode_now), 128'(m_mode));
        @(posedge clk);
        model_clock();
        @(negedge clk);
    endtask

    task automatic rand_data();
        logic [32*14-1:0] w;
        for (int i = 0; i < 14; i++) w[i*32 +: 32] = $urandom;
        src_data = w[NSRC*BUS_W-1:0];
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [35:0] prev;
        logic [NSRC*NGRP-1:0] en_r;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        chk(grp_busy == '0, "R9 busy", 128'(grp_busy), 128'(0));
        chk(bus_data == '0, "R9 bus", 128'(bus_data), 128'(0));
        chk(grp_owner == '0, "R9 owner", 128'(grp_owner), 128'(0));
        chk(mode_now == 2'd0, "R9 mode", 128'(mode_now), 128'(0));

        // R8: quiet bus accepts a new partition (code 2 = 36-bit lanes)
        mode_sel = 2'd2;
        step();
        chk(mode_now == 2'd2, "R8 mode applied", 128'(mode_now), 128'(2));

        // R1/R2: source 2 on group 3, source 1 on group 1, same cycle
        rand_data();
        src_en[2*NGRP+3] = 1'b1;
        src_en[1*NGRP+1] = 1'b1;
        step();
        chk(grp_busy == 12'h00F, "R1 lane busy", 128'(grp_busy), 128'(12'h00F));
        chk(grp_owner[0 +: 8] == 8'b01010101, "R2 lowest wins", 128'(grp_owner[0 +: 8]),
            128'(8'b01010101));
        // R3/R5: owner data on the lane, locked-out source absent
        chk(bus_data[35:0] == src_data[1*BUS_W +: 36], "R5 owner data",
            128'(bus_data[35:0]), 128'(src_data[1*BUS_W +: 36]));
        // R8: change request while busy is ignored
        mode_sel = 2'd0;
        step();
        chk(mode_now == 2'd2, "R8 ignored while busy", 128'(mode_now), 128'(2));
        chk(grp_owner[1:0] == 2'd1, "R3 owner kept", 128'(grp_owner[1:0]), 128'(1));
        prev = bus_data[35:0];
        // R4: owner releases; lane not driven this cycle
        src_en[1*NGRP+1] = 1'b0;
        rand_data();
        #1;
        chk(bus_data[35:0] == prev, "R4 release holds", 128'(bus_data[35:0]), 128'(prev));
        step();
        chk(grp_busy[3:0] == 4'h0, "R4 idle after release", 128'(grp_busy[3:0]), 128'(0));
        step();
        chk(grp_owner[1:0] == 2'd2 && grp_busy[0], "R4 handover", 128'(grp_owner[1:0]),
            128'(2));
        src_en = '0;
        step();
        step();

        // R7: forced even-parity group from the owner
        mode_sel = 2'd0;
        step();
        src_en[0*NGRP+5] = 1'b1;
        step();
        src_data[0*BUS_W + 5*GRP_W +: GRP_W] = 9'b000000011;
        #1;
        chk(parity_err[5] == 1'b1, "R7 even parity", 128'(parity_err), 128'(12'h020));
        step();
        src_en = '0;
        step();
        step();

        // constrained random phases
        en_r = '0;
        for (int ph = 0; ph < 30; ph++) begin
            for (int c = 0; c < 100; c++) begin
                for (int b = 0; b < NSRC*NGRP; b++)
                    if (($urandom % 10) == 0) en_r[b] = ~en_r[b];
                src_en = en_r;
                rand_data();
                if (($urandom % 16) == 0) mode_sel = 2'($urandom);
                step();
            end
            en_r = '0;
            src_en = '0;
            mode_sel = 2'($urandom);
            repeat (3) step();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule